// File: doc/BRIEF.md
# Age-Ordered Reservation Station with Per-Port Selection

This block holds decoded micro-operations that wait for their source operands and sends each one to an execution port once its operands are available. Every entry already carries the execution port it must use, chosen upstream before the entry is written. Inside the station the entries are kept packed from slot 0 upward in the order in which they arrived. Slot position alone therefore gives relative age.

In every cycle each execution port has its own selector. A selector looks only at the entries bound to its port and picks the one in the lowest slot among those whose sources are all ready. All picked entries leave at the next clock edge. The survivors shift down to close the holes, and any newly written entries are placed directly behind them.

Operand wakeup works through a small set of tag broadcasts. A broadcast marks a matching source ready at once. An entry that wakes this way can be dispatched in the same cycle. Entries being written in the same cycle also see the broadcast.

Top module: `rs_age_picker`

## Requirements
- R1: After reset the station is empty: every `dsp_vld` bit is 0 and `ins_full` is 0 while `ins_cnt` is 0. Entries present when reset is applied are discarded.
- R2: Dispatch lane p only ever carries an entry bound to port p. While `dsp_vld[p]` is 1, `dsp_port[p]` equals p.
- R3: On each port, the selected entry is the oldest eligible entry bound to that port. Age means order of entry into the station: an earlier cycle is older, and within one cycle a lower insert slot is older. The cycle in which an entry became ready plays no part.
- R4: An entry is eligible only when all of its source ready bits (bit s for source s) are set. An entry that is not ready stays in the station and is never dispatched.
- R5: A broadcast with `wk_vld[w]` = 1 and `wk_tag[w]` equal to a pending source tag sets that source's ready bit. The change counts for selection in the same cycle and is kept afterwards. It also applies to entries that are being inserted in that cycle.
- R6: A request writes insert slots 0 to `ins_cnt`-1 (at most INS_W). The new entries sit behind all surviving entries, and an entry can first be dispatched in the cycle after it was written.
- R7: `ins_full` is 1 when `ins_cnt` exceeds the free slots, meaning DEPTH minus the occupancy at the start of the cycle. In that case none of the requested entries is written.
- R8: A request for exactly the number of free slots is accepted. Entries dispatched in a cycle free their slots from the next cycle onward.
- R9: Up to one entry per port is dispatched in a cycle, and the ports choose independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_cnt | input | INS_CW | Number of insert slots offered this cycle (0..INS_W) |
| ins_port | input | INS_W x PORT_W | Bound execution port of each insert slot |
| ins_pay | input | INS_W x PAY_W | Payload of each insert slot |
| ins_tag | input | INS_W x NSRC x TAG_W | Source operand tags of each insert slot |
| ins_rdy | input | INS_W x NSRC | Source ready bits of each insert slot |
| ins_full | output | 1 | Request refused: not enough free slots |
| wk_vld | input | NWAKE | Wakeup broadcast valid bits |
| wk_tag | input | NWAKE x TAG_W | Wakeup broadcast tags |
| dsp_vld | output | NPORT | Dispatch valid, one bit per port |
| dsp_pay | output | NPORT x PAY_W | Payload dispatched on each port |
| dsp_port | output | NPORT x PORT_W | Bound port of the entry dispatched on each lane |

## Verification
The assertions take three things for granted about the inputs:
- `ins_cnt` never exceeds INS_W.
- Each live source tag is unique, so that a broadcast wakes only the operand meant for it.
- The insert fields and wakeup fields are held stable from just after one clock edge to the next.

The stimulus keeps within these limits. Every request asks for four or fewer entries. Each source tag is built from the low payload bits and the source index, and the payloads are picked so that no two live entries share a tag, except where one broadcast is meant to wake a whole group. All inputs change only one time unit after the rising edge.

// File: rtl/rs_pkg.sv
package rs_pkg;

    parameter int NPORT  = 4;
    parameter int PORT_W = $clog2(NPORT);
    parameter int NSRC   = 2;
    parameter int TAG_W  = 4;
    parameter int PAY_W  = 8;
    parameter int NWAKE  = 2;

    typedef logic [NSRC-1:0][TAG_W-1:0]  src_tags_t;
    typedef logic [NWAKE-1:0][TAG_W-1:0] wake_tags_t;

    typedef struct packed {
        logic              vld;
        logic [PORT_W-1:0] port;
        logic [PAY_W-1:0]  pay;
        logic [NSRC-1:0]   rdy;
        src_tags_t         tag;
    } rs_entry_t;

    // Which sources of an entry match any live broadcast.
    function automatic logic [NSRC-1:0] tag_hits(input src_tags_t tags,
                                                 input logic [NWAKE-1:0] wv,
                                                 input wake_tags_t wt);
        logic [NSRC-1:0] h;
        h = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int w = 0; w < NWAKE; w++) begin
                if (wv[w] && (wt[w] == tags[s])) h[s] = 1'b1;
            end
        end
        return h;
    endfunction

    function automatic rs_entry_t apply_wake(input rs_entry_t e,
                                             input logic [NWAKE-1:0] wv,
                                             input wake_tags_t wt);
        rs_entry_t r;
        r     = e;
        r.rdy = e.rdy | tag_hits(e.tag, wv, wt);
        return r;
    endfunction

    function automatic logic entry_ready(input rs_entry_t e);
        return e.vld && (&e.rdy);
    endfunction

endpackage

// File: rtl/rs_wakeup.sv
module rs_wakeup
    import rs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  rs_entry_t [DEPTH-1:0]  q_in,
    input  logic      [NWAKE-1:0]  wk_vld,
    input  wake_tags_t             wk_tag,
    output rs_entry_t [DEPTH-1:0]  q_out,
    output logic      [DEPTH-1:0]  rdy
);

    // Same-cycle bypass: the stored bits plus this cycle's broadcasts.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign q_out[e] = apply_wake(q_in[e], wk_vld, wk_tag);
        assign rdy[e]   = entry_ready(apply_wake(q_in[e], wk_vld, wk_tag));
    end

endmodule

// File: rtl/rs_port_pick.sv
module rs_port_pick
    import rs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  rs_entry_t [DEPTH-1:0]              q,
    input  logic      [DEPTH-1:0]              rdy,
    output logic      [NPORT-1:0]              dsp_vld,
    output logic      [NPORT-1:0][PAY_W-1:0]   dsp_pay,
    output logic      [NPORT-1:0][PORT_W-1:0]  dsp_port,
    output logic      [DEPTH-1:0]              taken
);

    logic [NPORT-1:0][DEPTH-1:0] gnt_all;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [DEPTH-1:0]  cand;
        logic [DEPTH-1:0]  gnt;
        logic [PAY_W-1:0]  pay;
        logic [PORT_W-1:0] prt;

        always_comb begin
            for (int e = 0; e < DEPTH; e++) begin
                cand[e] = rdy[e] && (q[e].port == PORT_W'(p));
            end
        end

        // Slot 0 holds the oldest entry: isolate the lowest set bit.
        assign gnt = cand & (~cand + DEPTH'(1));

        always_comb begin
            pay = '0;
            prt = '0;
            for (int e = 0; e < DEPTH; e++) begin
                if (gnt[e]) begin
                    pay = pay | q[e].pay;
                    prt = prt | q[e].port;
                end
            end
        end

        assign gnt_all[p]  = gnt;
        assign dsp_vld[p]  = |cand;
        assign dsp_pay[p]  = pay;
        assign dsp_port[p] = prt;
    end

    always_comb begin
        taken = '0;
        for (int p = 0; p < NPORT; p++) taken = taken | gnt_all[p];
    end

endmodule

// File: rtl/rs_collapse.sv
module rs_collapse
    import rs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int INS_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  rs_entry_t [DEPTH-1:0] q,
    input  logic      [DEPTH-1:0] keep,
    input  rs_entry_t [INS_W-1:0] ins_e,
    input  logic      [INS_W-1:0] ins_take,
    output rs_entry_t [DEPTH-1:0] q_nxt
);

    // Survivors slide down in order, accepted inserts follow them.
    always_comb begin
        int k;
        q_nxt = '0;
        k     = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                if (k < DEPTH) q_nxt[IDX_W'(k)] = q[i];
                k = k + 1;
            end
        end
        for (int j = 0; j < INS_W; j++) begin
            if (ins_take[j]) begin
                if (k < DEPTH) q_nxt[IDX_W'(k)] = ins_e[j];
                k = k + 1;
            end
        end
    end

endmodule

// File: rtl/rs_age_picker.sv
module rs_age_picker
    import rs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int INS_W = 4,
    localparam int INS_CW = $clog2(INS_W + 1),
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [INS_CW-1:0]                      ins_cnt,
    input  logic [INS_W-1:0][PORT_W-1:0]           ins_port,
    input  logic [INS_W-1:0][PAY_W-1:0]            ins_pay,
    input  logic [INS_W-1:0][NSRC-1:0][TAG_W-1:0]  ins_tag,
    input  logic [INS_W-1:0][NSRC-1:0]             ins_rdy,
    output logic                                   ins_full,
    input  logic [NWAKE-1:0]                       wk_vld,
    input  logic [NWAKE-1:0][TAG_W-1:0]            wk_tag,
    output logic [NPORT-1:0]                       dsp_vld,
    output logic [NPORT-1:0][PAY_W-1:0]            dsp_pay,
    output logic [NPORT-1:0][PORT_W-1:0]           dsp_port
);

    rs_entry_t [DEPTH-1:0] q_r;
    rs_entry_t [DEPTH-1:0] q_wk;
    rs_entry_t [DEPTH-1:0] q_nxt;
    rs_entry_t [INS_W-1:0] ins_e;
    logic      [INS_W-1:0] ins_take;
    logic      [DEPTH-1:0] rdy;
    logic      [DEPTH-1:0] taken;
    logic      [DEPTH-1:0] keep;
    logic      [OCC_W-1:0] occ;

    always_comb begin
        occ = '0;
        for (int e = 0; e < DEPTH; e++) occ = occ + OCC_W'(q_r[e].vld);
    end

    // Refusal is judged on start-of-cycle occupancy.
    assign ins_full = int'(ins_cnt) > (DEPTH - int'(occ));

    always_comb begin
        rs_entry_t t;
        for (int j = 0; j < INS_W; j++) begin
            t.vld       = 1'b1;
            t.port      = ins_port[j];
            t.pay       = ins_pay[j];
            t.rdy       = ins_rdy[j];
            t.tag       = ins_tag[j];
            ins_e[j]    = apply_wake(t, wk_vld, wk_tag);
            ins_take[j] = !ins_full && (j < int'(ins_cnt));
        end
    end

    rs_wakeup #(.DEPTH(DEPTH)) u_wake (
        .q_in   (q_r),
        .wk_vld (wk_vld),
        .wk_tag (wk_tag),
        .q_out  (q_wk),
        .rdy    (rdy)
    );

    rs_port_pick #(.DEPTH(DEPTH)) u_pick (
        .q        (q_wk),
        .rdy      (rdy),
        .dsp_vld  (dsp_vld),
        .dsp_pay  (dsp_pay),
        .dsp_port (dsp_port),
        .taken    (taken)
    );

    always_comb begin
        for (int e = 0; e < DEPTH; e++) keep[e] = q_wk[e].vld && !taken[e];
    end

    rs_collapse #(.DEPTH(DEPTH), .INS_W(INS_W)) u_coll (
        .q        (q_wk),
        .keep     (keep),
        .ins_e    (ins_e),
        .ins_take (ins_take),
        .q_nxt    (q_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nxt;
    end

endmodule

// File: rtl/rs_age_picker_chk.sv
module rs_age_picker_chk
    import rs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int INS_W = 4,
    localparam int INS_CW = $clog2(INS_W + 1),
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [INS_CW-1:0]             ins_cnt,
    input logic                          ins_full,
    input logic [NPORT-1:0]              dsp_vld,
    input logic [NPORT-1:0][PORT_W-1:0]  dsp_port,
    input logic [OCC_W-1:0]              occ
);

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == '0 && dsp_vld == '0));

    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ins_cnt) <= INS_W);

    a_r6_occ_after_accept: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ins_full)) |->
        int'(occ) == int'($past(occ)) - $past($countones(dsp_vld)) + int'($past(ins_cnt)));

    a_r7_occ_after_refuse: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ins_full)) |->
        int'(occ) == int'($past(occ)) - $past($countones(dsp_vld)));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

    a_r9_lanes_within_occupancy: assert property (@(posedge clk) disable iff (rst)
        $countones(dsp_vld) <= int'(occ));

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        a_r2_lane_port: assert property (@(posedge clk) disable iff (rst)
            dsp_vld[p] |-> dsp_port[p] == PORT_W'(p));
    end

endmodule

bind rs_age_picker rs_age_picker_chk #(.DEPTH(DEPTH), .INS_W(INS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_cnt  (ins_cnt),
    .ins_full (ins_full),
    .dsp_vld  (dsp_vld),
    .dsp_port (dsp_port),
    .occ      (occ)
);

// File: tb/rs_age_picker_tb.sv
module rs_age_picker_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [2:0]            ins_cnt;
    logic [3:0][1:0]       ins_port;
    logic [3:0][7:0]       ins_pay;
    logic [3:0][1:0][3:0]  ins_tag;
    logic [3:0][1:0]       ins_rdy;
    logic                  ins_full;
    logic [1:0]            wk_vld;
    logic [1:0][3:0]       wk_tag;
    logic [3:0]            dsp_vld;
    logic [3:0][7:0]       dsp_pay;
    logic [3:0][1:0]       dsp_port;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    rs_age_picker #(.DEPTH(8), .INS_W(4)) u_dut (
        .clk(clk), .rst(rst), .ins_cnt(ins_cnt), .ins_port(ins_port),
        .ins_pay(ins_pay), .ins_tag(ins_tag), .ins_rdy(ins_rdy),
        .ins_full(ins_full), .wk_vld(wk_vld), .wk_tag(wk_tag),
        .dsp_vld(dsp_vld), .dsp_pay(dsp_pay), .dsp_port(dsp_port)
    );

    // One cycle of stimulus: ports/rdy packed two bits per slot,
    // payload of slot k = base + k, wake tags four bits per lane,
    // expected payload eight bits per port.
    typedef struct packed {
        logic [2:0]  cnt;
        logic [7:0]  base;
        logic [7:0]  ports;
        logic [7:0]  rdys;
        logic [1:0]  wv;
        logic [7:0]  wt;
        logic        full;
        logic [3:0]  ev;
        logic [31:0] ep;
    } row_t;

    localparam int NROW = 13;
    localparam row_t TABLE [NROW] = '{
        // R6: inserted ready entries are not picked in their write cycle
        '{3'd4, 8'h10, 8'h50, 8'hEF, 2'b00, 8'h00, 1'b0, 4'b0000, 32'h0000_0000},
        // R3/R4: p1 skips unready 12 and takes 13
        '{3'd0, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 4'b0011, 32'h0000_1310},
        // R5: wake of tag 4 lets 12 go in the same cycle
        '{3'd2, 8'h20, 8'h09, 8'h0F, 2'b01, 8'h04, 1'b0, 4'b0011, 32'h0000_1211},
        '{3'd4, 8'h30, 8'hF6, 8'hCF, 2'b00, 8'h00, 1'b0, 4'b0110, 32'h0021_2000},
        // R8: exact fit of four; R3: 33 passes unready 32
        '{3'd4, 8'h40, 8'h0F, 8'hFD, 2'b00, 8'h00, 1'b0, 4'b1110, 32'h3330_3100},
        // R7: four requested with three free -> refused; R3: woken 40 beats 41
        '{3'd4, 8'h50, 8'h00, 8'hFF, 2'b01, 8'h01, 1'b1, 4'b1001, 32'h4000_0042},
        // R3: 32 woken late is still oldest on p3; R8: freed slots reused
        '{3'd4, 8'h60, 8'hE4, 8'hFF, 2'b11, 8'h54, 1'b0, 4'b1001, 32'h3200_0043},
        // R9: all four ports fire at once
        '{3'd0, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 4'b1111, 32'h4162_6160},
        // R5: wake hits 81 while it is being written
        '{3'd3, 8'h80, 8'h3F, 8'h30, 2'b11, 8'h32, 1'b0, 4'b1000, 32'h6300_0000},
        '{3'd0, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 4'b1000, 32'h8100_0000},
        '{3'd0, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 4'b1000, 32'h8200_0000},
        '{3'd0, 8'h00, 8'h00, 8'h00, 2'b11, 8'h10, 1'b0, 4'b1000, 32'h8000_0000},
        '{3'd0, 8'h00, 8'h00, 8'h00, 2'b00, 8'h00, 1'b0, 4'b0000, 32'h0000_0000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int n, input logic [31:0] pays,
                        input logic [7:0] ports, input logic [7:0] rdys);
        ins_cnt = 3'(n);
        for (int j = 0; j < 4; j++) begin
            ins_pay[j]  = pays[8*j +: 8];
            ins_port[j] = ports[2*j +: 2];
            ins_rdy[j]  = rdys[2*j +: 2];
            for (int s = 0; s < 2; s++) ins_tag[j][s] = {pays[8*j +: 3], 1'(s)};
        end
    endtask

    task automatic wake(input logic [1:0] v, input logic [7:0] t);
        wk_vld    = v;
        wk_tag[0] = t[3:0];
        wk_tag[1] = t[7:4];
    endtask

    task automatic check_disp(input string req, input logic [3:0] ev,
                              input logic [31:0] ep);
        check(req, "dsp_vld", 32'(dsp_vld), 32'(ev));
        for (int p = 0; p < 4; p++) begin
            if (ev[p]) begin
                check(req, "dsp_pay", 32'(dsp_pay[p]), 32'(ep[8*p +: 8]));
                check("R2", "dsp_port", 32'(dsp_port[p]), 32'(p));
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        load(0, 32'h0, 8'h0, 8'h0);
        wake(2'b00, 8'h00);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #4;
        // R1: empty and quiet after reset
        check("R1", "dsp_vld", 32'(dsp_vld), 32'h0);
        check("R1", "ins_full", 32'(ins_full), 32'h0);

        for (int r = 0; r < NROW; r++) begin
            tick();
            b = TABLE[r].base;
            load(int'(TABLE[r].cnt), {b + 8'd3, b + 8'd2, b + 8'd1, b},
                 TABLE[r].ports, TABLE[r].rdys);
            wake(TABLE[r].wv, TABLE[r].wt);
            #4;
            check("R7", "ins_full", 32'(ins_full), 32'(TABLE[r].full));
            check("R3", "row", 32'(dsp_vld), 32'(TABLE[r].ev));
            check_disp("R3", TABLE[r].ev, TABLE[r].ep);
        end

        // Fill with unready p0 entries whose tags are all 0/1
        tick(); load(4, 32'h2018_1008, 8'h00, 8'h00); wake(2'b00, 8'h00); #4;
        check("R8", "ins_full", 32'(ins_full), 32'h0);
        tick(); load(3, 32'h0038_3028, 8'h00, 8'h00); #4;
        check("R8", "ins_full", 32'(ins_full), 32'h0);
        // R8: seven held, one requested, one free -> accepted
        tick(); load(1, 32'h0000_0040, 8'h00, 8'h00); #4;
        check("R8", "ins_full", 32'(ins_full), 32'h0);
        // R7: station full, extra entry 48 refused
        tick(); load(1, 32'h0000_0048, 8'h00, 8'h00); #4;
        check("R7", "ins_full", 32'(ins_full), 32'h1);
        check_disp("R4", 4'b0000, 32'h0);
        // R5/R3: one broadcast readies all; drained oldest first
        tick(); load(0, 32'h0, 8'h00, 8'h00); wake(2'b11, 8'h10); #4;
        check_disp("R5", 4'b0001, 32'h0000_0008);
        tick(); wake(2'b00, 8'h00); #4;
        check_disp("R3", 4'b0001, 32'h0000_0010);
        tick(); #4; check_disp("R3", 4'b0001, 32'h0000_0018);
        tick(); #4; check_disp("R3", 4'b0001, 32'h0000_0020);
        tick(); #4; check_disp("R3", 4'b0001, 32'h0000_0028);
        tick(); #4; check_disp("R3", 4'b0001, 32'h0000_0030);
        tick(); #4; check_disp("R3", 4'b0001, 32'h0000_0038);
        tick(); #4; check_disp("R3", 4'b0001, 32'h0000_0040);
        // R7: refused 48 would now be ready if it had been written
        tick(); #4; check_disp("R7", 4'b0000, 32'h0);

        // R1: entries held at reset are discarded
        tick(); load(2, 32'h0000_1008, 8'h05, 8'h00); #4;
        tick(); load(0, 32'h0, 8'h00, 8'h00); rst = 1'b1; #4;
        tick(); rst = 1'b0; wake(2'b11, 8'h10); #4;
        check_disp("R1", 4'b0000, 32'h0);
        tick(); #4;
        check_disp("R1", 4'b0000, 32'h0);
        wake(2'b00, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule